// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block collects twelve single-cycle event pulses into one status word and drives a single active-high interrupt line towards a host processor. Every pulse sets a sticky status bit. The bit stays set until the host reads the status word, and that read clears every bit it returned. A second word holds one mask bit per source. Only status bits whose mask bit is 0 can drive the interrupt line.

The host reaches both words through a plain synchronous register port. The port has an address, a write strobe with write data, and a read strobe. Read data appears one cycle after the read strobe. The twelve sources sit on a sparse layout in the 16-bit word, and the unused positions always read as zero. After reset every source is masked and no event is pending. Software therefore has to unmask the sources it cares about before any interrupt can reach it.

Top module: `irq_agg_top`

## Requirements
- R1: A read at address 0x18 returns the status word. Source index i for i = 0..9 appears at bit i, source 10 at bit 12 and source 11 at bit 13. Bits 10, 11, 14 and 15 read as 0.
- R2: A status read clears every status bit that it returns. A second status read straight after it, with no new pulse, returns 0.
- R3: A source pulse in the same cycle as a status read is not cleared by that read. The next status read returns it.
- R4: Status bits latch whether or not the source is masked. A masked pending event keeps the interrupt low.
- R5: A write at address 0x20 loads the mask word, where 1 blocks a source and 0 passes it. Writes to bits 10, 11, 14 and 15 are ignored, and those bits read back as 0.
- R6: After reset the mask word reads 0x33FF, so every source is masked.
- R7: `irq` is registered and equals the OR over all bits of (status AND NOT mask). It changes on the same clock edge that updates the status or mask word, so unmasking a pending event raises it on the edge of the mask write.
- R8: Host writes to address 0x18 have no effect on the status word.
- R9: Read data is valid in the cycle after `rd_en`. It is 0 in any cycle that follows no read, and 0 after a read of any unmapped address.
- R10: Reset is synchronous and active low. It clears all status bits, `irq` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 12 | One-cycle event pulses, one per source |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid one cycle after `rd_en` |
| irq | output | 1 | Active-high interrupt request |

## Verification
A stuck or wrongly cleared status bit reaches the ports through the next status read one cycle after `rd_en`. It also reaches them through `irq` on the very next edge once its source is unmasked. A corrupt mask bit shows on `irq` on the edge after the first event on that source, or on a mask read one cycle later. The bench compares `rd_data` and `irq` with a behavioural model after every edge, so any divergence is reported within one cycle of the edge that caused it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Sources below GAP_POS map straight through; the rest skip GAP_W bits.
    localparam int GAP_POS = 10;
    localparam int GAP_W   = 2;

    function automatic int src_bit(input int idx);
        return (idx < GAP_POS) ? idx : idx + GAP_W;
    endfunction

    function automatic logic [63:0] used_mask(input int n_src);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < n_src; i++) begin
            m[src_bit(i)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_agg_pkg::*;
#(
    parameter int SRC_N  = 12,
    parameter int DATA_W = 16
) (
    input  logic [SRC_N-1:0]  src,
    output logic [DATA_W-1:0] word
);

    always_comb begin
        word = '0;
        for (int i = 0; i < SRC_N; i++) begin
            word[src_bit(i)] = src[i];
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] stat_d_o,
    output logic [DATA_W-1:0] stat_q_o
);

    typedef struct packed {
        logic [DATA_W-1:0] stat;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A set on the same cycle as a clear wins, so no pulse is lost.
        st_d.stat = (st_q.stat & ~clr_vec) | set_vec;
        if (!rst_n) begin
            st_d.stat = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stat_d_o = st_d.stat;
    assign stat_q_o = st_q.stat;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int DATA_W = 16,
    parameter logic [DATA_W-1:0] USED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] mask_d_o,
    output logic [DATA_W-1:0] mask_q_o
);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } mreg_t;

    mreg_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (load) begin
            m_d.mask = load_val & USED;
        end
        if (!rst_n) begin
            m_d.mask = USED;
        end
    end

    always_ff @(posedge clk) begin
        m_q <= m_d;
    end

    assign mask_d_o = m_d.mask;
    assign mask_q_o = m_q.mask;

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int                SRC_N     = 12,
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h18,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam logic [DATA_W-1:0] USED = DATA_W'(used_mask(SRC_N));

    typedef struct packed {
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } port_t;

    port_t p_d, p_q;

    logic [DATA_W-1:0] evt_word;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] stat_d, stat_q;
    logic [DATA_W-1:0] mask_d, mask_q;
    logic              rd_stat, rd_mask, wr_mask;

    assign rd_stat = rd_en && (addr == STAT_ADDR);
    assign rd_mask = rd_en && (addr == MASK_ADDR);
    assign wr_mask = wr_en && (addr == MASK_ADDR);
    assign clr_vec = rd_stat ? stat_q : '0;

    irq_src_map #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_map (
        .src  (src_evt),
        .word (evt_word)
    );

    irq_status_bank #(.DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (evt_word),
        .clr_vec  (clr_vec),
        .stat_d_o (stat_d),
        .stat_q_o (stat_q)
    );

    irq_mask_reg #(.DATA_W(DATA_W), .USED(USED)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_mask),
        .load_val (wr_data),
        .mask_d_o (mask_d),
        .mask_q_o (mask_q)
    );

    always_comb begin
        p_d       = p_q;
        p_d.rdata = '0;
        if (rd_stat) begin
            p_d.rdata = stat_q;
        end else if (rd_mask) begin
            p_d.rdata = mask_q;
        end
        // Built from next values so irq moves on the same edge as the words.
        p_d.irq = |(stat_d & ~mask_d);
        if (!rst_n) begin
            p_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
    end

    assign rd_data = p_q.rdata;
    assign irq     = p_q.irq;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int                SRC_N     = 12,
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h18,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  src_evt,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq
);

    localparam logic [DATA_W-1:0] USED = DATA_W'(used_mask(SRC_N));

    // R1 / R5: unused positions never read as 1
    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED) == '0);

    // R2: back-to-back status reads with no pulse before the second
    a_r2_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STAT_ADDR && src_evt == '0) ##1 (rd_en && addr == STAT_ADDR)
        |=> rd_data == '0);

    // R5: a mask write followed by a mask read returns the written used bits
    a_r5_mask_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MASK_ADDR) ##1 (rd_en && addr == MASK_ADDR && !wr_en)
        |=> rd_data == ($past(wr_data, 2) & USED));

    // R7: masking every source drops the line on the next edge
    a_r7_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MASK_ADDR && (wr_data & USED) == USED) |=> !irq);

    // R9: no read, no data
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);

    // R10: leaving reset, the line is low
    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && rd_data == '0));

endmodule

bind irq_agg_top irq_agg_chk #(
    .SRC_N(SRC_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq)
);

// File: tb/irq_agg_top_tb.sv
`timescale 1ns/1ps
module irq_agg_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_evt = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [15:0] m_stat, m_mask, m_rdata;
    logic        m_irq;

    always #2.5 clk = ~clk;

    irq_agg_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [15:0] spread(input logic [11:0] s);
        return {2'b00, s[11:10], 2'b00, s[9:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [11:0] s, input logic [7:0] a, input logic w,
                        input logic [15:0] d, input logic r);
        src_evt = s; addr = a; wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        if (!rst_n) begin
            m_stat = '0; m_mask = 16'h33FF; m_rdata = '0; m_irq = 1'b0;
        end else begin
            m_rdata = !r ? 16'h0 : (a == 8'h18) ? m_stat : (a == 8'h20) ? m_mask : 16'h0;
            if (r && a == 8'h18) m_stat = '0;
            m_stat = m_stat | spread(s);
            if (w && a == 8'h20) m_mask = d & 16'h33FF;
            m_irq = |(m_stat & ~m_mask);
        end
        @(negedge clk);
        check("R9 rd_data vs model", rd_data, m_rdata);
        check("R7 irq vs model", {15'd0, irq}, {15'd0, m_irq});
    endtask

    task automatic idle();
        step('0, '0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        step(12'hFFF, 8'h20, 1'b1, 16'h0000, 1'b1);
        idle(); idle();
        check("R10 rd_data in reset", rd_data, 16'h0);
        check("R10 irq in reset", {15'd0, irq}, 16'h0);
        rst_n = 1'b1;

        // R6: reset mask
        step('0, 8'h20, 1'b0, '0, 1'b1);
        check("R6 reset mask", rd_data, 16'h33FF);

        // R4 + R1: masked events latch, irq stays low, sparse layout
        step(12'hC01, '0, 1'b0, '0, 1'b0);
        check("R4 masked irq low", {15'd0, irq}, 16'h0);
        step('0, 8'h18, 1'b0, '0, 1'b1);
        check("R1 sparse status", rd_data, 16'h3001);
        // R2: second read empty
        step('0, 8'h18, 1'b0, '0, 1'b1);
        check("R2 cleared after read", rd_data, 16'h0);

        // R8: status write ignored
        step(12'h004, '0, 1'b0, '0, 1'b0);
        step('0, 8'h18, 1'b1, 16'hFFFF, 1'b0);
        step('0, 8'h18, 1'b0, '0, 1'b1);
        check("R8 status write ignored", rd_data, 16'h0004);

        // R5: unused mask bits
        step('0, 8'h20, 1'b1, 16'hFFFF, 1'b0);
        step('0, 8'h20, 1'b0, '0, 1'b1);
        check("R5 mask unused bits", rd_data, 16'h33FF);
        step('0, 8'h20, 1'b1, 16'h0000, 1'b0);
        step('0, 8'h20, 1'b0, '0, 1'b1);
        check("R5 mask cleared", rd_data, 16'h0000);

        // R7: unmasked event raises irq, read drops it
        step(12'h020, '0, 1'b0, '0, 1'b0);
        check("R7 irq raised", {15'd0, irq}, 16'h1);
        step('0, 8'h18, 1'b0, '0, 1'b1);
        check("R7 irq dropped after read", {15'd0, irq}, 16'h0);

        // R3: pulse during a status read survives
        step(12'h001, '0, 1'b0, '0, 1'b0);
        step(12'h008, 8'h18, 1'b0, '0, 1'b1);
        check("R3 read returns older bit", rd_data, 16'h0001);
        check("R3 irq held by new pulse", {15'd0, irq}, 16'h1);
        step('0, 8'h18, 1'b0, '0, 1'b1);
        check("R3 pulse kept", rd_data, 16'h0008);

        // R4/R7: pending masked event, unmask raises irq on the write edge
        step('0, 8'h20, 1'b1, 16'hFFFF, 1'b0);
        step(12'h040, '0, 1'b0, '0, 1'b0);
        check("R4 masked pending", {15'd0, irq}, 16'h0);
        step('0, 8'h20, 1'b1, 16'hFFBF, 1'b0);
        check("R7 unmask raises irq", {15'd0, irq}, 16'h1);

        // R9: unmapped address
        step('0, 8'h24, 1'b0, '0, 1'b1);
        check("R9 unmapped read", rd_data, 16'h0);

        // R10: reset mid-run clears pending status
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        step('0, 8'h18, 1'b0, '0, 1'b1);
        check("R10 status cleared by reset", rd_data, 16'h0);

        // mixed traffic against the model
        step('0, 8'h20, 1'b1, 16'h0F0F, 1'b0);
        for (int i = 0; i < 400; i++) begin
            logic [2:0] sel;
            sel = 3'($urandom_range(0, 7));
            step(12'($urandom) & 12'($urandom),
                 (sel < 3) ? 8'h18 : (sel < 6) ? 8'h20 : 8'h10,
                 ($urandom_range(0, 7) == 0),
                 16'($urandom),
                 ($urandom_range(0, 2) == 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule